// File: doc/BRIEF.md
# Key-Value Firmware Configuration Port

This block gives boot firmware a compact window onto a table of configuration items. The firmware picks an item by writing a 16-bit key into a selector. It then moves through the bytes of that item over a single byte-wide data port. Each read or accepted write steps an internal byte cursor forward, so reading an item is a plain run of data reads. Keys carry two flags. One chooses between a generic bank and an architecture-local bank. The other marks the item as writable, which lets firmware hand results back to the platform.

The table holds two banks of sixteen entries, each with up to eight bytes. A host-side load port fills it while the block is held in reset. Two generic entries are fixed in hardware: a four-byte ASCII signature and a 32-bit interface version. When firmware writes the last byte of a writable entry, the block emits a one-cycle completion pulse carrying the entry index and rewinds the cursor. The platform can then act on the new contents.

Top module: `kvcfg_port`

## Requirements
- R1: A selector write (`sel_we`) sets the byte cursor to zero. In a cycle where `sel_we` is high, data reads and writes on that cycle are ignored.
- R2: Key bit 15 selects the bank (0 generic, 1 architecture-local). Key bit 14 is the write-enable flag. Key bits 13:0 give the entry index. The write flag does not change which storage an entry uses, so bytes written under key 0x4000|n read back under key n.
- R3: A selector value whose bits 13:4 are not all zero is stored as the invalid key 0xFFFF. Under that key, reads return 0x00 and writes change nothing.
- R4: Under a valid key with cursor below the entry length, `dat_rdata` shows the byte at the cursor, and a read strobe moves the cursor on by one. When the cursor has reached the length, including entries of length 0, `dat_rdata` is 0x00 and reads do not move the cursor.
- R5: A data write is taken only when the key has bit 14 set, is valid, and the cursor is below the entry length. The byte goes to position cursor and the cursor moves on. Any other data write leaves the cursor and the contents unchanged.
- R6: When a taken write moves the cursor to the entry length, `done_o` is high for exactly the next cycle, `done_idx` gives the entry index, and the cursor returns to zero.
- R7: While `rst` is high, the key becomes 0, the cursor becomes 0 and `done_o` is low.
- R8: Generic entry 0 reads as the four bytes "K","V","F","W" in that order. Generic entry 1 reads as the 32-bit value 1, least significant byte first (01 00 00 00). Both have length 4. Both are restored on every reset, and load-port writes to them are ignored.
- R9: While `rst` is high, a `cfg_we` cycle loads one entry. Its length comes from `cfg_len`, and values above 8 are taken as 8. Byte k comes from `cfg_data[8k+7:8k]`, so numeric items are least significant byte first. `cfg_we` with `rst` low has no effect.
- R10: If a data write and a data read arrive in the same cycle, only the write is applied. The cursor moves on by at most one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| sel_we | input | 1 | Selector write strobe |
| sel_key | input | 16 | Key written to the selector |
| dat_wr | input | 1 | Data write strobe |
| dat_wdata | input | 8 | Data write byte |
| dat_rd | input | 1 | Data read strobe (advances the cursor) |
| dat_rdata | output | 8 | Byte at the cursor, or 0x00 |
| done_o | output | 1 | One-cycle completion pulse of a writable entry |
| done_idx | output | 4 | Index of the completed entry |
| cfg_we | input | 1 | Load-port entry write (honoured only in reset) |
| cfg_bank | input | 1 | Load-port bank |
| cfg_idx | input | 4 | Load-port entry index |
| cfg_len | input | 4 | Load-port entry length in bytes |
| cfg_data | input | 64 | Load-port entry bytes, byte 0 in the low bits |

## Verification
Several events can land in one cycle. A final write that completes an entry can meet a simultaneous read strobe. A selector write can meet a data write or a read. The bench drives these pairings on purpose, for example `dat_wr` together with `dat_rd` on the last byte of a writable entry, and `sel_we` together with `dat_wr`. A behavioural model applies the stated priority (selector, then write, then read). Each cycle the model's expected byte and completion pulse are compared with the outputs. A length-1 writable entry written twice in a row shows whether the completion pulses come back to back and the cursor rewinds each time.

// File: rtl/kvcfg_pkg.sv
package kvcfg_pkg;

    localparam int KEY_W      = 16;
    localparam int BANK_BIT   = 15;
    localparam int WCH_BIT    = 14;
    localparam int N_BANK     = 2;
    localparam int N_ENT      = 16;
    localparam int IDX_W      = $clog2(N_ENT);
    localparam int MAX_BYTES  = 8;
    localparam int LEN_W      = $clog2(MAX_BYTES + 1);
    localparam int BSEL_W     = $clog2(MAX_BYTES);
    localparam int WORD_W     = 8 * MAX_BYTES;
    localparam int N_FIXED    = 2;
    localparam int FIXED_LEN  = 4;

    localparam logic [KEY_W-1:0] KEY_INVALID = '1;
    localparam logic [31:0]      SIG_WORD    = "KVFW";
    localparam logic [31:0]      VER_WORD    = 32'd1;

    typedef struct packed {
        logic             valid;
        logic             bank;
        logic             wch;
        logic [IDX_W-1:0] idx;
    } key_dec_t;

    // Index bits above the entry range make the key invalid.
    function automatic logic key_in_range(input logic [KEY_W-1:0] k);
        return (k[WCH_BIT-1:IDX_W] == '0);
    endfunction

    function automatic key_dec_t decode_key(input logic [KEY_W-1:0] k);
        key_dec_t d;
        d.valid = (k != KEY_INVALID);
        d.bank  = k[BANK_BIT];
        d.wch   = k[WCH_BIT];
        d.idx   = k[IDX_W-1:0];
        return d;
    endfunction

    // Byte image of a hardware-fixed generic entry, byte 0 in the low bits.
    function automatic logic [WORD_W-1:0] fixed_image(input int idx);
        logic [WORD_W-1:0] img;
        img = '0;
        for (int k = 0; k < FIXED_LEN; k++) begin
            if (idx == 0) img[8*k +: 8] = SIG_WORD[31-8*k -: 8];
            else          img[8*k +: 8] = VER_WORD[8*k +: 8];
        end
        return img;
    endfunction

endpackage

// File: rtl/kvcfg_store.sv
module kvcfg_store
    import kvcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_bank,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [WORD_W-1:0] cfg_data,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BSEL_W-1:0] wr_off,
    input  logic [7:0]        wr_byte,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [BSEL_W-1:0] rd_off,
    output logic [LEN_W-1:0]  rd_len,
    output logic [7:0]        rd_byte
);
    localparam int N_TOT = N_BANK * N_ENT;

    logic [N_TOT*LEN_W-1:0]  len_all;
    logic [N_TOT*WORD_W-1:0] dat_all;

    logic [LEN_W-1:0] cfg_len_clamped;
    assign cfg_len_clamped = (cfg_len > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : cfg_len;

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        for (genvar i = 0; i < N_ENT; i++) begin : g_ent
            localparam int  E     = b * N_ENT + i;
            localparam bit  FIXED = (b == 0) && (i < N_FIXED);
            logic [LEN_W-1:0]  len_q;
            logic [WORD_W-1:0] dat_q;
            logic              hit_wr;
            assign hit_wr = wr_en && (wr_bank == 1'(b)) && (wr_idx == IDX_W'(i));

            if (FIXED) begin : g_fixed
                always_ff @(posedge clk) begin
                    if (rst) begin
                        len_q <= LEN_W'(FIXED_LEN);
                        dat_q <= fixed_image(i);
                    end else if (hit_wr) begin
                        dat_q[8*wr_off +: 8] <= wr_byte;
                    end
                end
            end else begin : g_loadable
                logic hit_cfg;
                assign hit_cfg = rst && cfg_we && (cfg_bank == 1'(b)) && (cfg_idx == IDX_W'(i));
                always_ff @(posedge clk) begin
                    if (hit_cfg) begin
                        len_q <= cfg_len_clamped;
                        dat_q <= cfg_data;
                    end else if (!rst && hit_wr) begin
                        dat_q[8*wr_off +: 8] <= wr_byte;
                    end
                end
            end

            assign len_all[E*LEN_W +: LEN_W]   = len_q;
            assign dat_all[E*WORD_W +: WORD_W] = dat_q;
        end
    end

    logic [IDX_W:0]    rd_e;
    logic [WORD_W-1:0] rd_word;
    assign rd_e    = {rd_bank, rd_idx};
    assign rd_len  = len_all[rd_e*LEN_W +: LEN_W];
    assign rd_word = dat_all[rd_e*WORD_W +: WORD_W];
    assign rd_byte = rd_word[8*rd_off +: 8];

endmodule

// File: rtl/kvcfg_cursor.sv
module kvcfg_cursor
    import kvcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic [KEY_W-1:0]  sel_key,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [LEN_W-1:0]  ent_len,
    output logic              cur_bank,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [LEN_W-1:0]  off_q,
    output logic              rd_ok,
    output logic              wr_take,
    output logic              done_q,
    output logic [IDX_W-1:0]  done_idx_q
);
    logic [KEY_W-1:0] key_q;
    key_dec_t         dec;
    logic             wr_ok;
    logic             rd_take;
    logic [LEN_W-1:0] off_nx;

    always_comb begin
        dec     = decode_key(key_q);
        rd_ok   = dec.valid && (off_q < ent_len);
        wr_ok   = dec.valid && dec.wch && (off_q < ent_len);
        wr_take = dat_wr && !sel_we && wr_ok;
        rd_take = dat_rd && !dat_wr && !sel_we && rd_ok;
        off_nx  = off_q + LEN_W'(1);
    end

    assign cur_bank = dec.bank;
    assign cur_idx  = dec.idx;

    // Priority: selector, then write, then read.
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q      <= '0;
            off_q      <= '0;
            done_q     <= 1'b0;
            done_idx_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (sel_we) begin
                key_q <= key_in_range(sel_key) ? sel_key : KEY_INVALID;
                off_q <= '0;
            end else if (wr_take) begin
                if (off_nx == ent_len) begin
                    off_q      <= '0;
                    done_q     <= 1'b1;
                    done_idx_q <= dec.idx;
                end else begin
                    off_q <= off_nx;
                end
            end else if (rd_take) begin
                off_q <= off_nx;
            end
        end
    end

    assert_sel_rewind_R1: assert property (@(posedge clk) disable iff (rst)
        sel_we |=> (off_q == '0));

    assert_invalid_key_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_we && (sel_key[WCH_BIT-1:IDX_W] != '0)) |=> (key_q == KEY_INVALID));

    assert_readonly_key_R5: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !sel_we && !key_q[WCH_BIT]) |=> $stable(off_q));

    assert_done_rewind_R6: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ((off_q == '0) && $past(dat_wr)));

    assert_reset_state_R7: assert property (@(posedge clk)
        rst |=> ((key_q == '0) && (off_q == '0) && !done_q));

    assert_one_step_R10: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && dat_rd && !sel_we && !key_q[WCH_BIT]) |=> $stable(off_q));

endmodule

// File: rtl/kvcfg_port.sv
module kvcfg_port
    import kvcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sel_we,
    input  logic [15:0] sel_key,
    input  logic        dat_wr,
    input  logic [7:0]  dat_wdata,
    input  logic        dat_rd,
    output logic [7:0]  dat_rdata,
    output logic        done_o,
    output logic [3:0]  done_idx,
    input  logic        cfg_we,
    input  logic        cfg_bank,
    input  logic [3:0]  cfg_idx,
    input  logic [3:0]  cfg_len,
    input  logic [63:0] cfg_data
);
    logic              cur_bank;
    logic [IDX_W-1:0]  cur_idx;
    logic [LEN_W-1:0]  off_q;
    logic [LEN_W-1:0]  ent_len;
    logic [7:0]        ent_byte;
    logic              rd_ok;
    logic              wr_take;

    kvcfg_cursor u_cursor (
        .clk        (clk),
        .rst        (rst),
        .sel_we     (sel_we),
        .sel_key    (sel_key),
        .dat_wr     (dat_wr),
        .dat_rd     (dat_rd),
        .ent_len    (ent_len),
        .cur_bank   (cur_bank),
        .cur_idx    (cur_idx),
        .off_q      (off_q),
        .rd_ok      (rd_ok),
        .wr_take    (wr_take),
        .done_q     (done_o),
        .done_idx_q (done_idx)
    );

    kvcfg_store u_store (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_bank (cfg_bank),
        .cfg_idx  (cfg_idx),
        .cfg_len  (cfg_len),
        .cfg_data (cfg_data),
        .wr_en    (wr_take),
        .wr_bank  (cur_bank),
        .wr_idx   (cur_idx),
        .wr_off   (off_q[BSEL_W-1:0]),
        .wr_byte  (dat_wdata),
        .rd_bank  (cur_bank),
        .rd_idx   (cur_idx),
        .rd_off   (off_q[BSEL_W-1:0]),
        .rd_len   (ent_len),
        .rd_byte  (ent_byte)
    );

    assign dat_rdata = rd_ok ? ent_byte : 8'h00;

    assert_past_end_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (off_q >= ent_len) |-> (dat_rdata == 8'h00));

    assert_len_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (ent_len <= LEN_W'(MAX_BYTES)) && (off_q <= LEN_W'(MAX_BYTES)));

endmodule

// File: tb/test_kvcfg_port.sv
module test_kvcfg_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_we = 1'b0;
    logic [15:0] sel_key = '0;
    logic        dat_wr = 1'b0;
    logic [7:0]  dat_wdata = '0;
    logic        dat_rd = 1'b0;
    logic [7:0]  dat_rdata;
    logic        done_o;
    logic [3:0]  done_idx;
    logic        cfg_we = 1'b0;
    logic        cfg_bank = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [3:0]  cfg_len = '0;
    logic [63:0] cfg_data = '0;

    always #10 clk = ~clk;

    kvcfg_port i_kvcfg_port (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_key(sel_key),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
        .dat_rdata(dat_rdata), .done_o(done_o), .done_idx(done_idx),
        .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_idx(cfg_idx),
        .cfg_len(cfg_len), .cfg_data(cfg_data)
    );

    // Behavioural reference model
    int          m_len [2][16];
    logic [7:0]  m_mem [2][16][8];
    logic [15:0] m_key;
    int          m_off;
    bit          m_done;
    int          m_didx;
    bit          started = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    string       cur_req = "R7";

    localparam logic [7:0] SIG [4] = '{8'h4B, 8'h56, 8'h46, 8'h57};

    function automatic logic [7:0] exp_rdata();
        int b, i;
        b = m_key[15];
        i = m_key[3:0];
        if (m_key == 16'hFFFF) return 8'h00;
        if (m_off >= m_len[b][i]) return 8'h00;
        return m_mem[b][i][m_off];
    endfunction

    always @(posedge clk) begin
        int b, i, ln;
        bit ok;
        started = 1;
        if (rst) begin
            m_key = '0; m_off = 0; m_done = 0;
            for (int k = 0; k < 4; k++) begin
                m_mem[0][0][k] = SIG[k];
                m_mem[0][1][k] = (k == 0) ? 8'h01 : 8'h00;
            end
            m_len[0][0] = 4; m_len[0][1] = 4;
            if (cfg_we && !(cfg_bank == 1'b0 && cfg_idx < 4'd2)) begin
                m_len[cfg_bank][cfg_idx] = (cfg_len > 4'd8) ? 8 : int'(cfg_len);
                for (int k = 0; k < 8; k++) m_mem[cfg_bank][cfg_idx][k] = cfg_data[8*k +: 8];
            end
        end else begin
            m_done = 0;
            b  = m_key[15];
            i  = m_key[3:0];
            ok = (m_key != 16'hFFFF);
            ln = m_len[b][i];
            if (sel_we) begin
                m_key = (sel_key[13:4] != 0) ? 16'hFFFF : sel_key;
                m_off = 0;
            end else if (dat_wr) begin
                if (ok && m_key[14] && m_off < ln) begin
                    m_mem[b][i][m_off] = dat_wdata;
                    m_off++;
                    if (m_off == ln) begin
                        m_off = 0; m_done = 1; m_didx = i;
                    end
                end
            end else if (dat_rd) begin
                if (ok && m_off < ln) m_off++;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            logic [7:0] e;
            e = exp_rdata();
            n_cmp++;
            if (dat_rdata !== e) begin
                n_bad++;
                $display("FAIL %s dat_rdata got %h expected %h", cur_req, dat_rdata, e);
            end
            if (done_o !== m_done || (m_done && done_idx !== 4'(m_didx))) begin
                n_bad++;
                $display("FAIL %s done got %b/%0d expected %b/%0d", cur_req, done_o, done_idx, m_done, m_didx);
            end
        end
    end

    task automatic cyc(input bit sw, input logic [15:0] k, input bit w,
                       input logic [7:0] d, input bit r);
        @(negedge clk);
        sel_we = sw; sel_key = k; dat_wr = w; dat_wdata = d; dat_rd = r;
        cfg_we = 1'b0;
    endtask

    task automatic sel(input logic [15:0] k);  cyc(1, k, 0, 8'h00, 0); endtask
    task automatic rd(input int n);
        for (int j = 0; j < n; j++) cyc(0, 16'h0, 0, 8'h00, 1);
    endtask
    task automatic wr(input logic [7:0] d);    cyc(0, 16'h0, 1, d, 0); endtask
    task automatic idle(input int n);
        for (int j = 0; j < n; j++) cyc(0, 16'h0, 0, 8'h00, 0);
    endtask

    task automatic load(input bit b, input int i, input int ln);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = b; cfg_idx = 4'(i); cfg_len = 4'(ln);
        for (int k = 0; k < 8; k++) cfg_data[8*k +: 8] = 8'(b * 128 + i * 8 + k + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R9: load every loadable entry during reset; R8: try to overwrite a fixed one
        idle(2);
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i++)
                load(b[0], i, (b * 16 + i) % 9);
        load(1'b1, 15, 15);          // R9 clamp to 8
        @(negedge clk); cfg_we = 0;
        rst = 1'b0;
        // R9: load port ignored outside reset
        cur_req = "R9";
        load(1'b0, 5, 2);
        @(negedge clk); cfg_we = 0;
        cur_req = "R7";
        rd(5);                       // R7/R8 key 0 after reset: signature
        cur_req = "R8";
        sel(16'h0001); rd(5);
        cur_req = "R9";
        sel(16'h0005); rd(6);
        sel(16'h800F); rd(9);
        cur_req = "R4";
        sel(16'h0009); rd(2);        // length 0
        sel(16'h0008); rd(10);
        cur_req = "R2";
        sel(16'h8003); rd(2);
        sel(16'h8006); rd(5);
        cur_req = "R3";
        sel(16'h0010); rd(2); wr(8'hAA); idle(1);
        sel(16'hC123); wr(8'h55); rd(1);
        cur_req = "R5";
        sel(16'h0007); wr(8'h11); rd(2);   // read-only key: write ignored
        sel(16'h4009); wr(8'h22); idle(1); // length 0
        cur_req = "R6";
        sel(16'h4007);
        for (int j = 0; j < 7; j++) wr(8'hA0 + 8'(j));
        idle(2);
        sel(16'h0007); rd(8);
        cur_req = "R6";
        sel(16'hC003); wr(8'h77); wr(8'h78); wr(8'h79); idle(1);
        sel(16'h8003); rd(2);
        cur_req = "R10";
        sel(16'h4006);
        for (int j = 0; j < 6; j++) cyc(0, 16'h0, 1, 8'hC0 + 8'(j), 1);
        cyc(0, 16'h0, 1, 8'hEE, 1);
        sel(16'h0006); rd(7);
        cur_req = "R1";
        sel(16'h4008); wr(8'h31); wr(8'h32);
        cyc(1, 16'h0008, 1, 8'hFF, 1);
        rd(3);
        cyc(1, 16'h0001, 0, 8'h00, 1);
        rd(2);
        cur_req = "R8";
        sel(16'h4000); wr(8'h61); idle(1);
        sel(16'h0000); rd(2);
        cur_req = "R7";
        sel(16'h0008); rd(2);
        @(negedge clk); rst = 1'b1; sel_we = 0; dat_rd = 0;
        idle(2);
        @(negedge clk); rst = 1'b0;
        rd(5);
        sel(16'h0008); rd(3);
        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule